// File: doc/BRIEF.md
# Driver Impedance Calibration Sequencer

This block automates output-driver impedance trimming for a DDR2-class SSTL I/O bank. After a start pulse it uses a plain register-write port to put the bank into calibration mode and to program the bias and control registers. It then searches for the pull-up (PMOS) strength code and, after that, for the pull-down (NMOS) strength code. Between code steps it waits a programmable number of settle cycles before it looks at the comparator outputs. At the end it writes zeros to leave calibration mode, and it reports the final codes, a done flag and an error flag.

The comparator result comes in as one bit per monitor register, and each bit is the compare result of data bit 0 of its lane. The pull-up search needs all monitor bits at 1. The pull-down search looks only at monitor bit 0. The code it finds is written into setting fields that drive every data, mask and strobe pad. The analog comparator and the pads lie outside the block.

Top module: `drv_cal_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `err_o` and `wr_valid_o` are low, and it issues no write until `start_i` is seen.
- R2: A run begins with exactly these four writes, in this order: 0x64←0x0000, 0x66←0x001B, 0x68←0x0001, 0x70←0x0081.
- R3: `wr_valid_o`, `wr_addr_o` and `wr_data_o` stay unchanged while `wr_ready_i` is low. At most one write is outstanding, and a write is accepted in a cycle where `wr_valid_o` and `wr_ready_i` are both high.
- R4: Each code update writes 0x98 and then 0x9A, each with data {N,P,N,P}, where N is in bits 15:12 and 7:4 and P is in bits 11:8 and 3:0. Every N field carries the same value, and so does every P field.
- R5: In the pull-up phase N is 0 and P starts at 0xF and falls by one per step. The phase ends at the first P for which every `cmp_i` bit reads 1, and `pcode_o` then holds that P.
- R6: Between the pull-up and pull-down phases the block writes 0x66←0x0017.
- R7: In the pull-down phase P keeps its final value and N starts at 0x0 and rises by one per step. The phase ends at the first N for which `cmp_i[0]` reads 1, and `ncode_o` then holds that N.
- R8: After the 0x9A write of a step is accepted, the block waits `settle_i` cycles before it samples `cmp_i`.
- R9: Every run ends with 0x64←0x0000, 0x66←0x0000 and 0x68←0x0000, in that order. These are the last writes of the run, and `done_o` rises after them.
- R10: If P reaches 0x0 without a match, `err_o` is set, the pull-down phase and the 0x0017 write are skipped, and the exit writes still follow. `pcode_o` is then 0.
- R11: If N reaches 0xF without a match, `err_o` is set, `ncode_o` is 0xF, and the exit writes still follow.
- R12: `done_o` and `err_o` hold their values until the next accepted start, which clears both. `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| settle_i | input | SETTLE_W | Settle cycles after each code update |
| cmp_i | input | NUM_MON | Comparator bit for each monitor register |
| wr_ready_i | input | 1 | Register port accepts the current write |
| wr_valid_o | output | 1 | Register write request |
| wr_addr_o | output | 8 | Register write offset |
| wr_data_o | output | 16 | Register write data |
| pcode_o | output | 4 | Pull-up strength code |
| ncode_o | output | 4 | Pull-down strength code |
| busy_o | output | 1 | Calibration run in progress |
| done_o | output | 1 | Last run has completed |
| err_o | output | 1 | Last run hit the end of a search range |

## Verification
The bench builds the block with SETTLE_W=3 and NUM_MON=4. This lets the full settle range 0..7 be programmed, and it gives the pull-up search the four monitor bits that must all agree. The comparator model delays its result by four cycles, so a run gives the right codes only if the settle wait is honoured. The bench runs searches that match at both ends of the code range, runs searches with no match in either phase, and runs with the write port stalled.

// File: rtl/drv_cal_pkg.sv
package drv_cal_pkg;

  localparam int CODE_W = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 4 * CODE_W;

  localparam logic [ADDR_W-1:0] REG_TERM   = 8'h64;
  localparam logic [ADDR_W-1:0] REG_MODE   = 8'h66;
  localparam logic [ADDR_W-1:0] REG_MODE2  = 8'h68;
  localparam logic [ADDR_W-1:0] REG_BANK   = 8'h70;
  localparam logic [ADDR_W-1:0] REG_DRV_LO = 8'h98;
  localparam logic [ADDR_W-1:0] REG_DRV_HI = 8'h9A;

  localparam logic [DATA_W-1:0] VAL_ZERO    = 16'h0000;
  localparam logic [DATA_W-1:0] VAL_PULLUP  = 16'h001B;
  localparam logic [DATA_W-1:0] VAL_PULLDN  = 16'h0017;
  localparam logic [DATA_W-1:0] VAL_MODE2ON = 16'h0001;
  localparam logic [DATA_W-1:0] VAL_BANKSEL = 16'h0081;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ENTRY, ST_P_SET, ST_P_WAIT, ST_P_CHK,
    ST_N_MODE, ST_N_SET, ST_N_WAIT, ST_N_CHK, ST_EXIT, ST_FIN
  } cal_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;

  function automatic logic [DATA_W-1:0] pack_codes(input logic [CODE_W-1:0] p,
                                                   input logic [CODE_W-1:0] n);
    return {n, p, n, p};
  endfunction

endpackage

// File: rtl/drv_cal_wrport.sv
module drv_cal_wrport
  import drv_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  wr_cmd_t           cmd_i,
  input  logic              wr_ready_i,
  output logic              accept_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  logic    valid_q, valid_d;
  wr_cmd_t cmd_q, cmd_d;
  logic    cmd_en;

  assign accept_o = valid_q & wr_ready_i;
  assign cmd_en   = issue_i & ~valid_q;

  always_comb begin
    valid_d = valid_q;
    cmd_d   = cmd_q;
    if (cmd_en) begin
      valid_d = 1'b1;
      cmd_d   = cmd_i;
    end else if (accept_o) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cmd_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (cmd_en) cmd_q <= cmd_d;
    end
  end

  assign wr_valid_o = valid_q;
  assign wr_addr_o  = cmd_q.addr;
  assign wr_data_o  = cmd_q.data;

endmodule

// File: rtl/drv_cal_settle.sv
module drv_cal_settle #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                tick_i,
  input  logic [SETTLE_W-1:0] count_i,
  output logic                expired_o
);

  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;

  assign expired_o = (cnt_q == '0);
  assign cnt_en    = load_i | (tick_i & ~expired_o);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = count_i;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/drv_cal_codes.sv
module drv_cal_codes
  import drv_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              p_dec_i,
  input  logic              n_inc_i,
  output logic [CODE_W-1:0] pcode_o,
  output logic [CODE_W-1:0] ncode_o,
  output logic              p_end_o,
  output logic              n_end_o
);

  logic [CODE_W-1:0] p_q, p_d, n_q, n_d;
  logic              code_en;

  assign code_en = init_i | p_dec_i | n_inc_i;

  always_comb begin
    p_d = p_q;
    n_d = n_q;
    if (init_i) begin
      p_d = '1;
      n_d = '0;
    end else begin
      if (p_dec_i) p_d = p_q - 1'b1;
      if (n_inc_i) n_d = n_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= '0;
      n_q <= '0;
    end else if (code_en) begin
      p_q <= p_d;
      n_q <= n_d;
    end
  end

  assign pcode_o = p_q;
  assign ncode_o = n_q;
  assign p_end_o = (p_q == '0);
  assign n_end_o = (n_q == '1);

endmodule

// File: rtl/drv_cal_seq.sv
module drv_cal_seq
  import drv_cal_pkg::*;
#(
  parameter int SETTLE_W = 8,
  parameter int NUM_MON  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [NUM_MON-1:0]  cmp_i,
  input  logic                wr_ready_i,
  output logic                wr_valid_o,
  output logic [7:0]          wr_addr_o,
  output logic [15:0]         wr_data_o,
  output logic [3:0]          pcode_o,
  output logic [3:0]          ncode_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o
);

  localparam int IDX_W = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cal_st_e            st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               done_q, done_d, err_q, err_d;
  logic               flag_en;

  wr_cmd_t            cmd;
  logic               wr_state, last_wr, issue, accept;
  logic               settle_load, settle_tick, settle_done;
  logic               code_init, p_dec, n_inc, p_end, n_end;
  logic [CODE_W-1:0]  p_code, n_code;

  drv_cal_wrport u_wrport (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .issue_i    (issue),
    .cmd_i      (cmd),
    .wr_ready_i (wr_ready_i),
    .accept_o   (accept),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  drv_cal_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (settle_load),
    .tick_i    (settle_tick),
    .count_i   (settle_i),
    .expired_o (settle_done)
  );

  drv_cal_codes u_codes (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .init_i  (code_init),
    .p_dec_i (p_dec),
    .n_inc_i (n_inc),
    .pcode_o (p_code),
    .ncode_o (n_code),
    .p_end_o (p_end),
    .n_end_o (n_end)
  );

  // write script: offset and data for the current state and step
  always_comb begin
    cmd     = '0;
    last_wr = 1'b0;
    unique case (st_q)
      ST_ENTRY: begin
        unique case (idx_q)
          2'd0:    cmd = '{REG_TERM,  VAL_ZERO};
          2'd1:    cmd = '{REG_MODE,  VAL_PULLUP};
          2'd2:    cmd = '{REG_MODE2, VAL_MODE2ON};
          default: cmd = '{REG_BANK,  VAL_BANKSEL};
        endcase
        last_wr = (idx_q == 2'd3);
      end
      ST_P_SET, ST_N_SET: begin
        cmd.addr = (idx_q == 2'd0) ? REG_DRV_LO : REG_DRV_HI;
        cmd.data = pack_codes(p_code, n_code);
        last_wr  = (idx_q == 2'd1);
      end
      ST_N_MODE: begin
        cmd     = '{REG_MODE, VAL_PULLDN};
        last_wr = 1'b1;
      end
      ST_EXIT: begin
        unique case (idx_q)
          2'd0:    cmd = '{REG_TERM,  VAL_ZERO};
          2'd1:    cmd = '{REG_MODE,  VAL_ZERO};
          default: cmd = '{REG_MODE2, VAL_ZERO};
        endcase
        last_wr = (idx_q == 2'd2);
      end
      default: ;
    endcase
  end

  assign wr_state = (st_q == ST_ENTRY) || (st_q == ST_P_SET) || (st_q == ST_N_MODE) ||
                    (st_q == ST_N_SET) || (st_q == ST_EXIT);
  assign issue    = wr_state & ~wr_valid_o;

  // next-state logic
  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    done_d      = done_q;
    err_d       = err_q;
    code_init   = 1'b0;
    p_dec       = 1'b0;
    n_inc       = 1'b0;
    settle_load = 1'b0;
    settle_tick = 1'b0;

    if (wr_state && accept) begin
      if (last_wr) begin
        idx_d = '0;
        unique case (st_q)
          ST_ENTRY:  st_d = ST_P_SET;
          ST_P_SET:  begin st_d = ST_P_WAIT; settle_load = 1'b1; end
          ST_N_MODE: st_d = ST_N_SET;
          ST_N_SET:  begin st_d = ST_N_WAIT; settle_load = 1'b1; end
          default:   st_d = ST_FIN;
        endcase
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end

    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d      = ST_ENTRY;
          idx_d     = '0;
          done_d    = 1'b0;
          err_d     = 1'b0;
          code_init = 1'b1;
        end
      end
      ST_P_WAIT: begin
        settle_tick = 1'b1;
        if (settle_done) st_d = ST_P_CHK;
      end
      ST_P_CHK: begin
        if (&cmp_i) begin
          st_d = ST_N_MODE;
        end else if (p_end) begin
          err_d = 1'b1;
          st_d  = ST_EXIT;
        end else begin
          p_dec = 1'b1;
          st_d  = ST_P_SET;
        end
      end
      ST_N_WAIT: begin
        settle_tick = 1'b1;
        if (settle_done) st_d = ST_N_CHK;
      end
      ST_N_CHK: begin
        if (cmp_i[0]) begin
          st_d = ST_EXIT;
        end else if (n_end) begin
          err_d = 1'b1;
          st_d  = ST_EXIT;
        end else begin
          n_inc = 1'b1;
          st_d  = ST_N_SET;
        end
      end
      ST_FIN: begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: ;
    endcase
  end

  assign flag_en = (done_d != done_q) | (err_d != err_q);

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (flag_en) begin
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign pcode_o = p_code;
  assign ncode_o = n_code;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;

endmodule

module drv_cal_seq_chk #(
  parameter int SETTLE_W = 8,
  parameter int NUM_MON  = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_ready_i,
  input logic        wr_valid_o,
  input logic [7:0]  wr_addr_o,
  input logic [15:0] wr_data_o,
  input logic [3:0]  pcode_o,
  input logic [3:0]  ncode_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);

  logic set_wr;
  assign set_wr = wr_valid_o && ((wr_addr_o == 8'h98) || (wr_addr_o == 8'h9A));

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !wr_valid_o);  // R1

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));  // R3

  AST_FIELDS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |-> ((wr_data_o[15:12] == wr_data_o[7:4]) && (wr_data_o[11:8] == wr_data_o[3:0])));  // R4

  AST_FIELDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |-> ((wr_data_o[15:12] == ncode_o) && (wr_data_o[11:8] == pcode_o)));  // R4

  AST_P_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (pcode_o != $past(pcode_o))) |-> ((pcode_o + 4'd1) == $past(pcode_o)));  // R5

  AST_N_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && (ncode_o != $past(ncode_o))) |-> ((ncode_o == ($past(ncode_o) + 4'd1)) && $stable(pcode_o)));  // R7

  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !busy_o) |-> done_o);  // R10

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !done_o);  // R12

endmodule

bind drv_cal_seq drv_cal_seq_chk #(.SETTLE_W(SETTLE_W), .NUM_MON(NUM_MON)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ready_i (wr_ready_i),
  .wr_valid_o (wr_valid_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .pcode_o    (pcode_o),
  .ncode_o    (ncode_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/drv_cal_seq_bench.sv
module drv_cal_seq_bench;

  localparam int SW  = 3;
  localparam int NM  = 4;
  localparam int DLY = 4;

  logic          clk, rst_n, start, ready;
  logic [SW-1:0] settle;
  logic [NM-1:0] cmp;
  logic          wr_valid, busy, done, err;
  logic [7:0]    wr_addr;
  logic [15:0]   wr_data;
  logic [3:0]    pcode, ncode;

  drv_cal_seq #(.SETTLE_W(SW), .NUM_MON(NM)) u_drv_cal_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .settle_i(settle), .cmp_i(cmp),
    .wr_ready_i(ready), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .pcode_o(pcode), .ncode_o(ncode), .busy_o(busy), .done_o(done), .err_o(err)
  );

  int total = 0, bad = 0, cyc = 0, stall_mode = 0, hold_bad = 0;
  int pth [4];
  int nth;
  logic [23:0] wlog [0:127];
  int wcnt = 0;
  logic [23:0] elog [0:127];
  int ecnt;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      finish_run();
    end
  end

  always @(posedge clk) begin
    #2;
    ready <= (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  // comparator model: register shadows and a DLY-stage result pipe
  logic [15:0] m_mode, m_lo, m_hi;
  logic [NM-1:0] pipe [DLY];
  logic [NM-1:0] raw;
  logic prev_stall;
  logic [23:0] prev_cmd;

  always_comb begin
    logic [3:0] pl [4];
    pl[0] = m_lo[3:0]; pl[1] = m_lo[11:8]; pl[2] = m_hi[3:0]; pl[3] = m_hi[11:8];
    raw = '0;
    if (m_mode == 16'h001B) begin
      for (int k = 0; k < 4; k++) raw[k] = (pth[k] >= 0) && (int'(pl[k]) <= pth[k]);
    end else if (m_mode == 16'h0017) begin
      raw[0] = (int'(m_lo[7:4]) >= nth);
    end
  end

  always @(posedge clk) begin
    pipe[0] <= raw;
    for (int k = 1; k < DLY; k++) pipe[k] <= pipe[k-1];
  end
  assign cmp = pipe[DLY-1];

  always @(negedge clk) begin
    if (!rst_n) begin
      m_mode <= '0; m_lo <= '0; m_hi <= '0; prev_stall <= 1'b0;
    end else begin
      if (prev_stall && !(wr_valid && {wr_addr, wr_data} == prev_cmd)) hold_bad++;
      prev_stall <= wr_valid && !ready;
      prev_cmd   <= {wr_addr, wr_data};
      if (wr_valid && ready) begin
        if (wcnt < 128) wlog[wcnt] = {wr_addr, wr_data};
        wcnt++;
        if (wr_addr == 8'h66) m_mode <= wr_data;
        if (wr_addr == 8'h98) m_lo   <= wr_data;
        if (wr_addr == 8'h9A) m_hi   <= wr_data;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic epush(input logic [7:0] a, input logic [15:0] d);
    elog[ecnt] = {a, d};
    ecnt++;
  endtask

  // builds the expected write list and results from the requirements
  task automatic build_exp(output int ep, output int en, output bit ee, output bit npass);
    bit hit;
    ecnt = 0; ee = 0; npass = 0; en = 0;
    epush(8'h64, 16'h0000); epush(8'h66, 16'h001B); epush(8'h68, 16'h0001); epush(8'h70, 16'h0081);
    ep = 15;
    forever begin
      epush(8'h98, {4'h0, 4'(ep), 4'h0, 4'(ep)});
      epush(8'h9A, {4'h0, 4'(ep), 4'h0, 4'(ep)});
      hit = 1;
      for (int k = 0; k < 4; k++) if (!(pth[k] >= 0 && ep <= pth[k])) hit = 0;
      if (hit) break;
      if (ep == 0) begin ee = 1; break; end
      ep--;
    end
    if (!ee) begin
      npass = 1;
      epush(8'h66, 16'h0017);
      forever begin
        epush(8'h98, {4'(en), 4'(ep), 4'(en), 4'(ep)});
        epush(8'h9A, {4'(en), 4'(ep), 4'(en), 4'(ep)});
        if (en >= nth) break;
        if (en == 15) begin ee = 1; break; end
        en++;
      end
    end
    epush(8'h64, 16'h0000); epush(8'h66, 16'h0000); epush(8'h68, 16'h0000);
  endtask

  task automatic run_cal(input string name, input int p0, input int p1, input int p2, input int p3,
                         input int nt, input int st, input int stl, input bit restart);
    int ep, en, wait_c, first_bad;
    bit ee, npass, found17;
    pth[0] = p0; pth[1] = p1; pth[2] = p2; pth[3] = p3; nth = nt;
    settle = SW'(st); stall_mode = stl; hold_bad = 0;
    build_exp(ep, en, ee, npass);
    @(negedge clk); wcnt = 0;
    @(posedge clk); #2 start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    @(negedge clk);
    chk(busy && !done && !err, "R12", {name, " start clears flags"}, {busy, done, err}, 3'b100);
    if (restart) begin
      repeat (12) @(posedge clk);
      #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    wait_c = 0;
    while (!done && wait_c < 20000) begin @(negedge clk); wait_c++; end
    chk(done && !busy, "R9", {name, " done after run"}, {done, busy}, 2'b10);
    chk(wcnt == ecnt, "R4", {name, " write count"}, wcnt, ecnt);
    first_bad = -1;
    for (int i = 0; i < ecnt && i < wcnt; i++) if (wlog[i] !== elog[i] && first_bad < 0) first_bad = i;
    chk(first_bad < 0, restart ? "R12" : "R5", {name, " write list, first diff at index"}, first_bad, -1);
    chk(wlog[0] == 24'h640000 && wlog[1] == 24'h66001B && wlog[2] == 24'h680001 && wlog[3] == 24'h700081,
        "R2", {name, " entry writes"}, wlog[3], 24'h700081);
    found17 = 0;
    for (int i = 0; i < wcnt && i < 128; i++) if (wlog[i] == 24'h660017) found17 = 1;
    chk(found17 == npass, "R6", {name, " pull-down mode write"}, found17, npass);
    chk(wcnt >= 3 && wlog[wcnt-3] == 24'h640000 && wlog[wcnt-2] == 24'h660000 && wlog[wcnt-1] == 24'h680000,
        "R9", {name, " exit writes"}, (wcnt >= 1) ? wlog[wcnt-1] : 0, 24'h680000);
    chk(pcode == 4'(ep), "R5", {name, " pcode (settle R8)"}, pcode, ep);
    chk(ncode == 4'(en), "R7", {name, " ncode (settle R8)"}, ncode, en);
    chk(err == ee, ee ? (npass ? "R11" : "R10") : "R5", {name, " err flag"}, err, ee);
    chk(hold_bad == 0, "R3", {name, " write held while stalled"}, hold_bad, 0);
    repeat (15) @(negedge clk);
    chk(done && err == ee && wcnt == ecnt, "R12", {name, " flags held while idle"}, {done, err}, {1'b1, ee});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; settle = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !wr_valid, "R1", "reset outputs", {busy, done, err, wr_valid}, 0);
    #3 rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(!busy && !wr_valid && wcnt == 0, "R1", "idle without start", {busy, wr_valid}, 0);
  endtask

  initial begin
    ready = 1'b1;
    for (int k = 0; k < 4; k++) pth[k] = 0;
    nth = 0;
    t_reset();
    run_cal("mid",     9,  9,  9,  9,  5, 3, 0, 1'b0);
    run_cal("lanes",  12,  7, 10,  8,  0, 7, 1, 1'b1);
    run_cal("edges",  15, 15, 15, 15, 15, 3, 1, 1'b0);
    run_cal("p_fail", 15, -1, 15, 15,  3, 3, 0, 1'b0);
    run_cal("n_fail",  4,  6,  5,  4, 16, 3, 1, 1'b0);
    run_cal("recover", 3,  3,  3,  3,  2, 6, 0, 1'b0);
    finish_run();
  end

endmodule